// File: doc/BRIEF.md
# AXI Bus Performance Monitor

This block sits beside one AXI4 slave port and watches its five channels without driving any of them. While a measurement window is open it counts read and write address handshakes, write response handshakes, and the bytes moved on the read and write data channels. A free-running cycle counter measures the length of the window.

A processor controls the monitor through a small AXI4-Lite register port. It opens and closes the window, picks narrow (saturating) or wide counters, zeroes the counters, and reads back every metric. Software typically works in this order: clear, start, let traffic run, stop, then read the six metrics.

Top module: `axi_perf_mon`

## Requirements
- R1: While the window is open, a request is counted on each clock edge where AR valid and ready are both high (read requests) or AW valid and ready are both high (write requests). A valid without its ready counts nothing.
- R2: While the window is open, the write response count advances on each edge where B valid and B ready are both high.
- R3: While the window is open, each R handshake adds DW/8 to the read byte count. Each W handshake adds the number of set bits in the write strobe to the write byte count.
- R4: While the window is closed, monitored traffic changes no counter.
- R5: Writing the control word (offset 0x00) with bit 0 set opens the window, and with bit 1 set closes it. If both bits are set, the close wins. The cycle counter then equals the number of clock edges from the opening write's handshake to the closing write's handshake.
- R6: In narrow mode (control bit 8 = 0) every counter stops at 2^NARROW_W - 1 and does not wrap.
- R7: In wide mode (control bit 8 = 1) counters are 64 bits and do not saturate at the narrow limit. Each metric's low word is at its offset and its high word at offset+4. Reading the low word latches the full value, and the high-word read returns the latched upper half (in narrow mode the high word reads 0). Bit 8 is taken only while the window is closed, and changing it zeroes all counters.
- R8: Writing the control word with bit 2 set zeroes all counters, but only while the window is closed. While the window is open, the clear is ignored.
- R9: Metric offsets are: cycles 0x08, read bytes 0x10, write bytes 0x18, read requests 0x20, write requests 0x28, write responses 0x30. Reading offset 0x00 returns the window state in bit 0 and the wide-mode bit in bit 8.
- R10: After reset the window is closed, the mode is narrow, and every counter reads 0.
- R11: Each accepted register write produces one write response in the cycle after its handshake. Read data stays valid and unchanged until R ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_awvalid | input | 1 | Observed write address valid |
| mon_awready | input | 1 | Observed write address ready |
| mon_wvalid | input | 1 | Observed write data valid |
| mon_wready | input | 1 | Observed write data ready |
| mon_wstrb | input | DW/8 | Observed write strobes |
| mon_bvalid | input | 1 | Observed write response valid |
| mon_bready | input | 1 | Observed write response ready |
| mon_arvalid | input | 1 | Observed read address valid |
| mon_arready | input | 1 | Observed read address ready |
| mon_rvalid | input | 1 | Observed read data valid |
| mon_rready | input | 1 | Observed read data ready |
| s_awaddr | input | 6 | Register write address |
| s_awvalid | input | 1 | Register write address valid |
| s_awready | output | 1 | Register write address ready |
| s_wdata | input | 32 | Register write data |
| s_wvalid | input | 1 | Register write data valid |
| s_wready | output | 1 | Register write data ready |
| s_bresp | output | 2 | Write response code, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Register read address |
| s_arvalid | input | 1 | Register read address valid |
| s_arready | output | 1 | Register read address ready |
| s_rdata | output | 32 | Register read data |
| s_rresp | output | 2 | Read response code, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
A monitored handshake reaches its counter at the same edge it occurs on. A control write takes effect at its own handshake edge, and its write response is valid one cycle later. Register read data is registered, so it appears one cycle after the read address handshake. The bench drives every input at the falling edge and credits each handshake to the expected totals when it drives it, since the handshake is taken at the next rising edge. It reads each edge index and each register value back at the following falling edge, and measures the expected cycle count as the difference between the handshake edges of the opening and closing writes.

// File: rtl/axi_perf_mon.sv
module axi_perf_mon #(
  parameter int DW       = 32,
  parameter int NARROW_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mon_awvalid,
  input  logic            mon_awready,
  input  logic            mon_wvalid,
  input  logic            mon_wready,
  input  logic [DW/8-1:0] mon_wstrb,
  input  logic            mon_bvalid,
  input  logic            mon_bready,
  input  logic            mon_arvalid,
  input  logic            mon_arready,
  input  logic            mon_rvalid,
  input  logic            mon_rready,
  input  logic [5:0]      s_awaddr,
  input  logic            s_awvalid,
  output logic            s_awready,
  input  logic [31:0]     s_wdata,
  input  logic            s_wvalid,
  output logic            s_wready,
  output logic [1:0]      s_bresp,
  output logic            s_bvalid,
  input  logic            s_bready,
  input  logic [5:0]      s_araddr,
  input  logic            s_arvalid,
  output logic            s_arready,
  output logic [31:0]     s_rdata,
  output logic [1:0]      s_rresp,
  output logic            s_rvalid,
  input  logic            s_rready
);
  localparam int          NB   = DW / 8;
  localparam int          NC   = 6;
  localparam logic [63:0] NMAX = (64'd1 << NARROW_W) - 64'd1;

  logic        running, wide;
  logic [63:0] cnt  [NC];
  logic [63:0] inc  [NC];
  logic [63:0] sum  [NC];
  logic [63:0] hold;
  logic [31:0] rd_word;

  wire wr_fire  = s_awvalid & s_wvalid & ~s_bvalid;
  wire ctrl_wr  = wr_fire & (s_awaddr[5:2] == 4'd0);
  wire do_start = ctrl_wr & s_wdata[0];
  wire do_stop  = ctrl_wr & s_wdata[1];
  wire mode_wr  = ctrl_wr & ~running;
  wire do_clear = mode_wr & (s_wdata[2] | (s_wdata[8] != wide));

  wire       rd_fire = s_arvalid & ~s_rvalid;
  wire [2:0] idx     = s_araddr[5:3];
  wire       hi      = s_araddr[2];
  wire       is_met  = (idx != 3'd0) && (idx != 3'd7);
  wire [2:0] m       = idx - 3'd1;

  logic unused_bits;
  assign unused_bits = ^{s_awaddr[1:0], s_araddr[1:0], s_wdata[31:9], s_wdata[7:3]};

  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_arready = ~s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;

  assign inc[0] = 64'd1;
  assign inc[1] = (mon_rvalid  & mon_rready)  ? 64'(NB) : 64'd0;
  assign inc[2] = (mon_wvalid  & mon_wready)  ? 64'($countones(mon_wstrb)) : 64'd0;
  assign inc[3] = (mon_arvalid & mon_arready) ? 64'd1 : 64'd0;
  assign inc[4] = (mon_awvalid & mon_awready) ? 64'd1 : 64'd0;
  assign inc[5] = (mon_bvalid  & mon_bready)  ? 64'd1 : 64'd0;

  for (genvar g = 0; g < NC; g++) begin : g_cnt
    assign sum[g] = cnt[g] + inc[g];
    always_ff @(posedge clk) begin
      if (!rst_n || do_clear) cnt[g] <= '0;
      else if (running)       cnt[g] <= (wide || sum[g] <= NMAX) ? sum[g] : NMAX;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      wide     <= 1'b0;
      s_bvalid <= 1'b0;
    end else begin
      if (do_stop)       running <= 1'b0;
      else if (do_start) running <= 1'b1;
      if (mode_wr)       wide    <= s_wdata[8];
      if (wr_fire)       s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (idx == 3'd0 && !hi) rd_word = {23'd0, wide, 7'd0, running};
    else if (is_met)        rd_word = !hi ? cnt[m][31:0] : (wide ? hold[63:32] : 32'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
      hold     <= '0;
    end else if (rd_fire) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_word;
      if (is_met && !hi) hold <= cnt[m];
    end else if (s_rready) begin
      s_rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/axi_perf_mon_chk.sv
module axi_perf_mon_chk #(
  parameter int NARROW_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        running,
  input logic        wide,
  input logic [63:0] cyc,
  input logic        wr_fire,
  input logic        s_bvalid,
  input logic        s_rvalid,
  input logic        s_rready,
  input logic [31:0] s_rdata
);
  localparam logic [63:0] NMAX = (64'd1 << NARROW_W) - 64'd1;

  AST_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!running) && !$past(wr_fire)) |-> $stable(cyc)); // R4
  AST_NO_DROP_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) |-> cyc >= $past(cyc)); // R8
  AST_NARROW_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> cyc <= NMAX); // R6
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(running) && ($past(wide) || $past(cyc) < NMAX)) |-> cyc == $past(cyc) + 64'd1); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata))); // R11
  AST_BRESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> s_bvalid); // R11
endmodule

bind axi_perf_mon axi_perf_mon_chk #(.NARROW_W(NARROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running(running), .wide(wide), .cyc(cnt[0]),
  .wr_fire(wr_fire), .s_bvalid(s_bvalid), .s_rvalid(s_rvalid),
  .s_rready(s_rready), .s_rdata(s_rdata)
);

// File: tb/axi_perf_mon_bench.sv
`timescale 1ns/1ps
module axi_perf_mon_bench;
  localparam int DW = 32, NW = 10, NB = DW/8;
  localparam logic [63:0] NMAX = (64'd1 << NW) - 64'd1;

  logic clk = 0, rst_n = 0;
  logic awv = 0, awr = 0, wv = 0, wr = 0, bv = 0, br = 0, arv = 0, arr = 0, rv = 0, rr = 0;
  logic [NB-1:0] strb = '0;
  logic [5:0] s_awaddr = 0, s_araddr = 0;
  logic [31:0] s_wdata = 0, s_rdata;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 1, s_arvalid = 0, s_rready = 1;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;

  int edges = 0, nvec = 0, nerr = 0;
  logic [63:0] e_rb, e_wb, e_rr, e_wr, e_bb;

  always #2 clk = ~clk;
  always @(posedge clk) edges++;

  axi_perf_mon #(.DW(DW), .NARROW_W(NW)) u_axi_perf_mon (
    .clk(clk), .rst_n(rst_n),
    .mon_awvalid(awv), .mon_awready(awr), .mon_wvalid(wv), .mon_wready(wr), .mon_wstrb(strb),
    .mon_bvalid(bv), .mon_bready(br), .mon_arvalid(arv), .mon_arready(arr),
    .mon_rvalid(rv), .mon_rready(rr),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready), .s_wdata(s_wdata),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_bresp(s_bresp), .s_bvalid(s_bvalid),
    .s_bready(s_bready), .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lite_wr(input logic [31:0] d, output int at);
    @(negedge clk);
    s_awaddr = 6'h00; s_wdata = d; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk);
    at = edges; s_awvalid = 0; s_wvalid = 0;
    chk("R11 bvalid after write", s_bvalid, 1);
  endtask

  task automatic lite_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0; d = s_rdata;
  endtask

  task automatic rd64(input int idx, output logic [63:0] v);
    logic [31:0] lo, hi;
    lite_rd(6'(idx*8), lo);
    lite_rd(6'(idx*8+4), hi);
    v = {hi, lo};
  endtask

  function automatic logic [63:0] sat(input logic [63:0] v, input bit w);
    return (w || v <= NMAX) ? v : NMAX;
  endfunction

  task automatic zero_exp();
    e_rb = 0; e_wb = 0; e_rr = 0; e_wr = 0; e_bb = 0;
  endtask

  task automatic traffic(input int n, input bit live, input bit rd_only);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rd_only) begin
        {awv, awr, wv, wr, bv, br, arv, arr} = '0; rv = 1; rr = 1;
      end else begin
        {awv, awr, wv, wr, bv, br, arv, arr, rv, rr} = 10'($urandom);
        strb = NB'($urandom);
      end
      if (live) begin
        if (arv && arr) e_rr++;
        if (awv && awr) e_wr++;
        if (bv && br)   e_bb++;
        if (rv && rr)   e_rb += NB;
        if (wv && wr)   e_wb += $countones(strb);
      end
    end
    @(negedge clk);
    {awv, awr, wv, wr, bv, br, arv, arr, rv, rr} = '0; strb = '0;
  endtask

  task automatic check_all(input string tag, input bit w, input logic [63:0] ecyc);
    logic [63:0] v;
    rd64(1, v); chk({tag, " R5 cycles"}, v, sat(ecyc, w));
    rd64(2, v); chk({tag, " R3 read bytes"}, v, sat(e_rb, w));
    rd64(3, v); chk({tag, " R3 write bytes"}, v, sat(e_wb, w));
    rd64(4, v); chk({tag, " R1 read reqs"}, v, sat(e_rr, w));
    rd64(5, v); chk({tag, " R1 write reqs"}, v, sat(e_wr, w));
    rd64(6, v); chk({tag, " R2 write resps"}, v, sat(e_bb, w));
  endtask

  bit done = 0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int es, ep;
    logic [31:0] d, d1;
    logic [63:0] v, keep;
    void'($urandom(32'd20240601));
    repeat (3) @(negedge clk);
    rst_n = 1;
    zero_exp();
    lite_rd(6'h00, d); chk("R10 ctrl after reset", d, 0);
    check_all("R10 reset", 0, 0);

    lite_wr(32'h1, es);
    lite_rd(6'h00, d); chk("R9 ctrl running", d, 32'h1);
    traffic(50, 1, 0);
    lite_wr(32'h2, ep);
    check_all("R1 directed window", 0, 64'(ep - es));
    keep = 64'(ep - es);

    traffic(40, 0, 0);
    check_all("R4 stopped traffic", 0, keep);

    lite_wr(32'h1, es);
    lite_wr(32'h4, ep);
    lite_wr(32'h2, ep);
    rd64(4, v); chk("R8 clear ignored while running", v, e_rr);
    lite_wr(32'h4, ep);
    zero_exp();
    check_all("R8 clear stopped", 0, 0);

    lite_wr(32'h3, es);
    lite_rd(6'h00, d); chk("R5 stop wins", d, 32'h0);

    for (int k = 0; k < 3; k++) begin
      zero_exp();
      lite_wr(32'h5, es);
      traffic(20 + int'($urandom_range(40)), 1, 0);
      lite_wr(32'h2, ep);
      check_all("R3 random round", 0, 64'(ep - es));
    end

    zero_exp();
    lite_wr(32'h5, es);
    traffic(300, 1, 1);
    lite_wr(32'h2, ep);
    rd64(2, v); chk("R6 narrow saturation", v, NMAX);

    lite_wr(32'h100, ep);
    zero_exp();
    lite_rd(6'h00, d); chk("R7 wide mode bit", d, 32'h100);
    check_all("R7 mode change clears", 1, 0);
    lite_wr(32'h101, es);
    traffic(300, 1, 1);
    lite_wr(32'h102, ep);
    check_all("R7 wide", 1, 64'(ep - es));

    @(negedge clk);
    s_rready = 0; s_araddr = 6'h10; s_arvalid = 1;
    @(negedge clk);
    s_arvalid = 0; d1 = s_rdata;
    @(negedge clk);
    chk("R11 rvalid held", s_rvalid, 1);
    chk("R11 rdata stable", s_rdata, d1);
    s_rready = 1;
    @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule